// File: doc/BRIEF.md
# Delta-Sigma ADC SPI Command and Register Engine

This block is the host-side SPI master for a multichannel delta-sigma converter. A client hands it one request at a time: a control command, a single-register read or a single-register write. The engine turns the request into a byte frame on an SPI link in mode 1 (clock idles low, data launched on the rising edge and captured on the falling edge, most significant bit first). It returns a one-cycle completion pulse and, for reads, the byte fetched from the converter.

The converter needs time to decode a multi-byte command before its data phase begins. It also needs a quiet period after a reset command. Both delays are defined in converter master-clock periods. The engine converts them to system clocks through the parameter `ADC_CLK_RATIO`, which is the number of system clocks per converter clock. During the decode delay, chip select stays asserted and the serial clock is held still. During the post-reset delay, chip select is released and the engine stays busy.

The controller has five states. S_IDLE accepts a request. S_SHIFT moves one byte. S_DECODE holds the decode delay. S_SETTLE holds the post-reset quiet period. S_DONE emits the completion pulse. The transitions are:
- S_IDLE goes to S_SHIFT when a request arrives.
- S_SHIFT goes to S_SHIFT after the leading byte of a register access, to send the count byte.
- S_SHIFT goes to S_DECODE after the count byte.
- S_SHIFT goes to S_SETTLE after a reset command byte.
- S_SHIFT goes to S_DONE after any other single-byte command, or after the data byte of a register access.
- S_DECODE goes to S_SHIFT when the decode delay expires.
- S_SETTLE goes to S_DONE when the quiet period expires.
- S_DONE always returns to S_IDLE.

Top module: `adc_spi_cmd_engine`

## Requirements
- R1: After reset, `spi_cs_n` is high, `spi_sclk` is low, and both `busy` and `done` are low.
- R2: `req_op` values 0 to 5 each send exactly one byte under one chip-select period. The bytes are: 0 (reset) sends 0x06, 1 (start) sends 0x08, 2 (stop) sends 0x0A, 3 (offset calibration) sends 0x1A, 4 (leave continuous read) sends 0x11, and 5 (fetch data) sends 0x12.
- R3: `req_op` 6 reads one register. The frame sends 0x20 OR `req_addr`, then 0x00, then clocks in one byte. After `done`, that byte appears on `rd_data` and is held there until the next read completes.
- R4: `req_op` 7 writes one register. The frame sends three bytes: 0x40 OR `req_addr`, then 0x00, then `req_wdata`.
- R5: The link runs in SPI mode 1. `spi_sclk` is low whenever no byte is moving. `spi_mosi` changes only on rising edges of `spi_sclk` and is stable while `spi_sclk` is high. `spi_miso` is captured on falling edges. Every byte is sent most significant bit first.
- R6: In a register read or write, at least `DECODE_ADC_CYC*ADC_CLK_RATIO` system clocks pass between the last falling edge of the second byte and the first rising edge of the third byte. `spi_cs_n` stays low during this gap.
- R7: After the reset command byte, `spi_cs_n` goes high. `done` does not pulse until at least `RESET_ADC_CYC*ADC_CLK_RATIO` system clocks after that rising edge of `spi_cs_n`.
- R8: A `req_valid` seen while `busy` is high is ignored. It starts no frame, and it does not alter the bytes of the frame in progress.
- R9: Each accepted request produces exactly one `done` pulse, one cycle long. `busy` is low in the following cycle.
- R10: `spi_cs_n` is low for the whole of each frame, and `spi_sclk` never goes high while `spi_cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe; taken only while `busy` is low |
| req_op | input | 3 | Request kind, encoded as listed in R2 to R4 |
| req_addr | input | 5 | Register address for reads and writes |
| req_wdata | input | 8 | Value to write |
| busy | output | 1 | High from acceptance until the cycle of `done` |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Last register value read |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the converter |
| spi_miso | input | 1 | Serial data from the converter |

## Verification
The assertions assume that the request fields carry only the eight defined opcodes. They also assume that the converter-side line is driven only on rising clock edges while a read's data byte is being clocked in. The stimulus keeps to both assumptions. It draws `req_op` from the full 3-bit range, all of which is legal. It raises `req_valid` mainly while the engine is idle, apart from one deliberate mid-frame strobe used to test that busy requests are ignored. The bench's converter model updates `spi_miso` only on rising serial-clock edges.

// File: rtl/adc_spi_pkg.sv
package adc_spi_pkg;

    typedef enum logic [2:0] {
        OP_RESET     = 3'd0,
        OP_START     = 3'd1,
        OP_STOP      = 3'd2,
        OP_OFFCAL    = 3'd3,
        OP_HALTSTRM  = 3'd4,
        OP_FETCH     = 3'd5,
        OP_REGRD     = 3'd6,
        OP_REGWR     = 3'd7
    } req_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SHIFT,
        S_DECODE,
        S_SETTLE,
        S_DONE
    } eng_state_e;

    localparam logic [7:0] COUNT_BYTE = 8'h00;

    function automatic logic is_reg_access(req_op_e op);
        return (op == OP_REGRD) || (op == OP_REGWR);
    endfunction

    function automatic logic [7:0] lead_byte(req_op_e op, logic [4:0] addr);
        logic [7:0] b;
        unique case (op)
            OP_RESET:    b = 8'h06;
            OP_START:    b = 8'h08;
            OP_STOP:     b = 8'h0A;
            OP_OFFCAL:   b = 8'h1A;
            OP_HALTSTRM: b = 8'h11;
            OP_FETCH:    b = 8'h12;
            OP_REGRD:    b = {3'b001, addr};
            OP_REGWR:    b = {3'b010, addr};
            default:     b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/spi_mode1_shifter.sv
module spi_mode1_shifter #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic [7:0] rx_byte,
    output logic       byte_done
);
    localparam int DW = $clog2(HALF_DIV) + 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(HALF_DIV - 1);

    logic          active;
    logic [DW-1:0] div_cnt;
    logic [3:0]    phase;
    logic          sclk_q;
    logic          mosi_q;
    logic          done_q;
    logic [7:0]    tx_sh;
    logic [7:0]    rx_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active  <= 1'b0;
            div_cnt <= '0;
            phase   <= '0;
            sclk_q  <= 1'b0;
            mosi_q  <= 1'b0;
            done_q  <= 1'b0;
            tx_sh   <= '0;
            rx_sh   <= '0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                active  <= 1'b1;
                div_cnt <= '0;
                phase   <= '0;
                sclk_q  <= 1'b0;
                tx_sh   <= tx_byte;
            end else if (active) begin
                if (div_cnt == DIV_LAST) begin
                    div_cnt <= '0;
                    sclk_q  <= ~sclk_q;
                    phase   <= phase + 4'd1;
                    if (!sclk_q) begin
                        // rising edge: launch next bit, MSB first
                        mosi_q <= tx_sh[7];
                        tx_sh  <= {tx_sh[6:0], 1'b0};
                    end else begin
                        // falling edge: capture input bit
                        rx_sh <= {rx_sh[6:0], miso};
                        if (phase == 4'd15) begin
                            active <= 1'b0;
                            done_q <= 1'b1;
                        end
                    end
                end else begin
                    div_cnt <= div_cnt + DW'(1);
                end
            end
        end
    end

    assign sclk      = sclk_q;
    assign mosi      = mosi_q;
    assign rx_byte   = rx_sh;
    assign byte_done = done_q;

    AST_SCLK_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !start) |=> $stable(sclk_q)); // R5

    AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_q && $past(sclk_q)) |-> $stable(mosi_q)); // R5

endmodule

// File: rtl/gap_counter.sv
module gap_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] len,
    output logic         expire
);
    logic         running;
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (start) begin
            running <= 1'b1;
            cnt     <= len - W'(1);
        end else if (running) begin
            if (cnt == '0) running <= 1'b0;
            else           cnt     <= cnt - W'(1);
        end
    end

    assign expire = running && (cnt == '0);

    AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (len != '0)); // R6

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !expire) |-> !start); // R7

endmodule

// File: rtl/adc_spi_cmd_engine.sv
module adc_spi_cmd_engine
    import adc_spi_pkg::*;
#(
    parameter int HALF_DIV       = 2,
    parameter int ADC_CLK_RATIO  = 4,
    parameter int DECODE_ADC_CYC = 4,
    parameter int RESET_ADC_CYC  = 18
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [2:0] req_op,
    input  logic [4:0] req_addr,
    input  logic [7:0] req_wdata,
    output logic       busy,
    output logic       done,
    output logic [7:0] rd_data,
    output logic       spi_sclk,
    output logic       spi_cs_n,
    output logic       spi_mosi,
    input  logic       spi_miso
);
    localparam int DECODE_SYS = DECODE_ADC_CYC * ADC_CLK_RATIO;
    localparam int RESET_SYS  = RESET_ADC_CYC * ADC_CLK_RATIO;
    localparam int GAP_MAX    = (DECODE_SYS > RESET_SYS) ? DECODE_SYS : RESET_SYS;
    localparam int GW         = $clog2(GAP_MAX + 1);

    eng_state_e state, next_state;
    req_op_e    op_q;
    logic [4:0] addr_q;
    logic [7:0] wdata_q;
    logic [7:0] rd_q;
    logic [1:0] byte_idx;

    logic          sh_start;
    logic [7:0]    sh_byte;
    logic [7:0]    sh_rx;
    logic          sh_done;
    logic          gap_start;
    logic [GW-1:0] gap_len;
    logic          gap_expire;

    spi_mode1_shifter #(.HALF_DIV(HALF_DIV)) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (sh_start),
        .tx_byte   (sh_byte),
        .miso      (spi_miso),
        .sclk      (spi_sclk),
        .mosi      (spi_mosi),
        .rx_byte   (sh_rx),
        .byte_done (sh_done)
    );

    gap_counter #(.W(GW)) u_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (gap_start),
        .len    (gap_len),
        .expire (gap_expire)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= next_state;
    end

    // transitions and per-cycle control strobes
    always_comb begin
        next_state = state;
        sh_start   = 1'b0;
        sh_byte    = COUNT_BYTE;
        gap_start  = 1'b0;
        gap_len    = GW'(DECODE_SYS);
        unique case (state)
            S_IDLE: begin
                if (req_valid) begin
                    sh_start   = 1'b1;
                    sh_byte    = lead_byte(req_op_e'(req_op), req_addr);
                    next_state = S_SHIFT;
                end
            end
            S_SHIFT: begin
                if (sh_done) begin
                    if (!is_reg_access(op_q)) begin
                        if (op_q == OP_RESET) begin
                            gap_start  = 1'b1;
                            gap_len    = GW'(RESET_SYS);
                            next_state = S_SETTLE;
                        end else begin
                            next_state = S_DONE;
                        end
                    end else if (byte_idx == 2'd0) begin
                        sh_start = 1'b1;
                        sh_byte  = COUNT_BYTE;
                    end else if (byte_idx == 2'd1) begin
                        gap_start  = 1'b1;
                        next_state = S_DECODE;
                    end else begin
                        next_state = S_DONE;
                    end
                end
            end
            S_DECODE: begin
                if (gap_expire) begin
                    sh_start   = 1'b1;
                    sh_byte    = (op_q == OP_REGWR) ? wdata_q : COUNT_BYTE;
                    next_state = S_SHIFT;
                end
            end
            S_SETTLE: begin
                if (gap_expire) next_state = S_DONE;
            end
            S_DONE: next_state = S_IDLE;
            default: next_state = S_IDLE;
        endcase
    end

    // request capture and read data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= OP_RESET;
            addr_q   <= '0;
            wdata_q  <= '0;
            rd_q     <= '0;
            byte_idx <= '0;
        end else begin
            if (state == S_IDLE && req_valid) begin
                op_q     <= req_op_e'(req_op);
                addr_q   <= req_addr;
                wdata_q  <= req_wdata;
                byte_idx <= '0;
            end else if (sh_start) begin
                byte_idx <= byte_idx + 2'd1;
            end
            if (state == S_SHIFT && sh_done && byte_idx == 2'd2 && op_q == OP_REGRD)
                rd_q <= sh_rx;
        end
    end

    // outputs
    always_comb begin
        busy     = (state != S_IDLE);
        done     = (state == S_DONE);
        spi_cs_n = !((state == S_SHIFT) || (state == S_DECODE));
        rd_data  = rd_q;
    end

    AST_SCLK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> !spi_cs_n); // R10

    AST_GAP_CLOCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DECODE) |-> (!spi_sclk && !spi_cs_n)); // R6

    AST_SETTLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SETTLE) |-> (spi_cs_n && !spi_sclk)); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R9

    AST_IGNORE_BUSY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> ($stable(op_q) && $stable(addr_q) && $stable(wdata_q))); // R8

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |=> $stable(rd_q)); // R3

endmodule

// File: tb/test_adc_spi_cmd_engine.sv
`timescale 1ns/1ps
module test_adc_spi_cmd_engine;
    localparam int HALF_DIV = 2;
    localparam int RATIO    = 4;
    localparam int DEC_N    = 4 * RATIO;
    localparam int RST_N    = 18 * RATIO;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_op = '0;
    logic [4:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       busy, done, spi_sclk, spi_cs_n, spi_mosi;
    logic [7:0] rd_data;
    logic       spi_miso = 1'b0;

    always #2 clk = ~clk;

    adc_spi_cmd_engine #(
        .HALF_DIV(HALF_DIV), .ADC_CLK_RATIO(RATIO),
        .DECODE_ADC_CYC(4), .RESET_ADC_CYC(18)
    ) i_adc_spi_cmd_engine (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // converter model
    logic [7:0] slave_mem [32];
    logic [7:0] mdl [32];
    logic [7:0] cap [4];
    logic [7:0] cur = '0;
    int  nbits = 0;
    int  frames = 0;
    longint fall16_t = 0;
    longint gap_t = 0;
    longint cs_rise_t = 0;
    int  done_cnt = 0;
    int  mosi_glitch = 0;
    logic prev_sclk = 1'b0;
    logic prev_mosi = 1'b0;

    always @(negedge spi_cs_n) begin
        nbits = 0;
        frames++;
        gap_t = -1;
    end

    always @(posedge spi_cs_n) cs_rise_t = $time;

    always @(negedge spi_sclk) begin
        cur = {cur[6:0], spi_mosi};
        if (nbits < 32) nbits++;
        if (nbits % 8 == 0) begin
            cap[nbits/8 - 1] = cur;
            if (nbits == 24 && cap[0][7:5] == 3'b010) slave_mem[cap[0][4:0]] = cur;
        end
        if (nbits == 16) fall16_t = $time;
    end

    always @(posedge spi_sclk) begin
        if (nbits == 16) gap_t = $time - fall16_t;
        if (nbits >= 16 && nbits < 24 && cap[0][7:5] == 3'b001)
            spi_miso <= slave_mem[cap[0][4:0]][23 - nbits];
        else
            spi_miso <= 1'b0;
    end

    always @(posedge clk) begin
        if (spi_sclk && prev_sclk && spi_mosi != prev_mosi) mosi_glitch++;
        prev_sclk <= spi_sclk;
        prev_mosi <= spi_mosi;
    end

    always @(negedge clk) if (done) done_cnt++;

    function automatic logic [7:0] exp_lead(input int op, input int a);
        case (op)
            0: return 8'h06;
            1: return 8'h08;
            2: return 8'h0A;
            3: return 8'h1A;
            4: return 8'h11;
            5: return 8'h12;
            6: return 8'h20 | 8'(a);
            default: return 8'h40 | 8'(a);
        endcase
    endfunction

    function automatic logic [7:0] init_val(input int a);
        return 8'((a * 37 + 5) ^ 8'hA5);
    endfunction

    longint done_t;

    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (done) begin ok = 1'b1; done_t = $time; break; end
        end
    endtask

    task automatic run_req(input int op, input int a, input int wd, input bit inject);
        int f0, d0;
        bit ok;
        f0 = frames; d0 = done_cnt;
        @(negedge clk);
        req_valid = 1'b1; req_op = 3'(op); req_addr = 5'(a); req_wdata = 8'(wd);
        @(negedge clk);
        req_valid = 1'b0;
        if (inject) begin
            repeat (20) @(negedge clk);
            req_valid = 1'b1; req_op = 3'd6; req_addr = 5'(a ^ 5); req_wdata = 8'(~wd);
            @(negedge clk);
            req_valid = 1'b0;
        end
        wait_done(ok);
        chk(ok, "R9 done_seen", int'(ok), 1);
        if (!ok) return;
        @(negedge clk);
        chk(!busy, "R9 busy_after_done", int'(busy), 0);
        chk(done_cnt == d0 + 1, "R9 single_done", done_cnt - d0, 1);
        chk(frames == f0 + 1, "R10 one_frame", frames - f0, 1);
        chk(cap[0] == exp_lead(op, a), (op < 6) ? "R2 lead_byte" : "R3/R4 lead_byte",
            int'(cap[0]), int'(exp_lead(op, a)));
        if (op < 6) begin
            chk(nbits == 8, "R2 bit_count", nbits, 8);
            if (op == 0)
                chk(done_t - cs_rise_t >= RST_N * 4, "R7 reset_quiet",
                    int'((done_t - cs_rise_t) / 4), RST_N);
        end else begin
            chk(nbits == 24, "R10 bit_count", nbits, 24);
            chk(cap[1] == 8'h00, "R4 count_byte", int'(cap[1]), 0);
            chk(gap_t >= DEC_N * 4, "R6 decode_gap", int'(gap_t / 4), DEC_N);
            if (op == 7) begin
                chk(cap[2] == 8'(wd), "R4 data_byte", int'(cap[2]), wd & 255);
                mdl[a] = 8'(wd);
            end else begin
                chk(rd_data == mdl[a], "R3 rd_data", int'(rd_data), int'(mdl[a]));
            end
        end
    endtask

    initial begin
        for (int i = 0; i < 32; i++) begin
            slave_mem[i] = init_val(i);
            mdl[i] = init_val(i);
        end
        repeat (3) @(negedge clk);
        chk(spi_cs_n && !spi_sclk && !busy && !done, "R1 reset_state",
            {spi_cs_n, spi_sclk, busy, done}, 4'b1000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(spi_cs_n && !spi_sclk && !busy && !done, "R1 after_release",
            {spi_cs_n, spi_sclk, busy, done}, 4'b1000);

        // directed: every single-byte command
        for (int op = 0; op < 6; op++) run_req(op, 0, 0, 1'b0);
        // register corners
        run_req(6, 0, 0, 1'b0);
        run_req(6, 31, 0, 1'b0);
        run_req(7, 31, 8'hFF, 1'b0);
        run_req(6, 31, 0, 1'b0);
        run_req(7, 0, 8'h00, 1'b0);
        run_req(7, 17, 8'h81, 1'b0);
        run_req(6, 17, 0, 1'b0);
        // R8: request while busy is ignored
        run_req(7, 9, 8'h5C, 1'b1);
        begin
            int f0, d0;
            f0 = frames; d0 = done_cnt;
            repeat (200) @(negedge clk);
            chk(frames == f0, "R8 no_extra_frame", frames - f0, 0);
            chk(done_cnt == d0, "R8 no_extra_done", done_cnt - d0, 0);
        end
        run_req(6, 9, 0, 1'b0);
        run_req(6, 12, 0, 1'b0);
        chk(rd_data == mdl[12], "R8 target_untouched", int'(rd_data), int'(mdl[12]));

        // random mix
        void'($urandom(32'd2024));
        for (int k = 0; k < 60; k++) begin
            int op, a, wd;
            op = int'($urandom % 8);
            a  = int'($urandom % 32);
            wd = int'($urandom % 256);
            run_req(op, a, wd, 1'b0);
        end

        chk(mosi_glitch == 0, "R5 mosi_stable_high", mosi_glitch, 0);
        chk(!spi_sclk && spi_cs_n, "R5 idle_levels", {spi_sclk, spi_cs_n}, 2'b01);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R9 actual=hung expected=complete");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule